// File: doc/BRIEF.md
# Privilege-Qualified Event Counter Bank

The block holds a small bank of 32-bit event counters, up to four, each paired with a control register. Both registers of each pair sit on a simple register bus with a write strobe and a combinational read path. On every clock edge a counter adds one if its selected event pulse is high, the current privilege level is enabled in its control word, and the running thread passes the control word's thread filter.

Sampling-based profiling uses the top counter bit as an overflow flag. Software preloads a counter with 0x80000000 minus the desired period. Once that many qualified events have occurred, bit 31 becomes set and, if the counter's interrupt enable is on, a shared level-sensitive interrupt is raised. Writing the counter again clears the request. A chaining flag in each control word shows whether another counter follows it, so software can find out how many counters exist. A presence bit in a configuration word shows that the bank is implemented.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every counter reads 0, every control word reads 0 apart from its chaining flag (bit 31), the status word reads 0 and `irq_out` is low.
- R2: `cur_mode` encodes the privilege level as 0 user, 1 supervisor, 2 kernel, 3 exception level. Control bits 3, 2, 1 and 0 enable counting in user, supervisor, kernel and exception level respectively. A counter does not count in a level whose bit is clear.
- R3: Control bits 14:5 hold an event number n, and the counter counts cycles in which `evt_pulse[n]` is high. An event number of NUM_EVT or more never counts.
- R4: Control bits 21:20 filter by thread. Value 0 counts for every thread. Value 1 counts only when `cur_vpe` equals control bits 19:16. Value 2 counts only when `cur_tc` equals control bits 29:22. Value 3 never counts.
- R5: Control bit 31 reads 1 for every counter except the last, which reads 0. Control bit 30 always reads 0, and writes to it have no effect.
- R6: A qualified event on a clock edge makes the counter read one higher from the next cycle on. Counting continues past bit 31 and wraps from 0xFFFFFFFF to 0.
- R7: When a counter write and a qualified event occur at the same edge, the counter takes the written value.
- R8: `irq_out` is high exactly while some counter has bit 31 set and its interrupt enable (control bit 4) set. It rises in the cycle the counter reaches 0x80000000, so a preload of 0x80000000 minus P raises it after P events. It falls in the cycle after a write that clears bit 31 of the counter.
- R9: Address map: 0..NUM_CTR-1 select the control words, NUM_CTR..2*NUM_CTR-1 select the counters, 2*NUM_CTR selects the status word, whose bit 26 mirrors `irq_out`, and 2*NUM_CTR+1 selects the configuration word, which reads 0x10 (bit 4 = present). The status and configuration words are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cur_mode | input | 2 | Current privilege level |
| cur_vpe | input | 4 | Running virtual processor id |
| cur_tc | input | 8 | Running thread context id |
| evt_pulse | input | NUM_EVT | Event pulses, one per event number |
| irq_out | output | 1 | Level interrupt request |

## Verification
Register writes and counted events take effect at a clock edge, and the new value can be read on the combinational read port from the following cycle. `irq_out` follows the counter state in that same cycle, with no added delay. The bench drives writes and event pulses at falling edges. Its monitor compares each expected item against the read port or the interrupt a short time after the next falling edge, so the number of rising edges between stimulus and sample is known exactly. Event pulses are held high for a set number of rising edges, which gives an exact expected count.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int VPE_W     = 4;
  localparam int TC_W      = 8;
  localparam int EVT_SEL_W = 10;
  localparam int PEND_BIT  = 26;
  localparam int PRES_BIT  = 4;

  typedef enum logic [1:0] {
    MODE_USER   = 2'd0,
    MODE_SUPER  = 2'd1,
    MODE_KERNEL = 2'd2,
    MODE_EXC    = 2'd3
  } priv_mode_e;

  typedef enum logic [1:0] {
    FLT_ANY  = 2'd0,
    FLT_VPE  = 2'd1,
    FLT_TC   = 2'd2,
    FLT_NONE = 2'd3
  } thr_filt_e;

  typedef struct packed {
    logic [TC_W-1:0]      tc_id;
    thr_filt_e            filt;
    logic [VPE_W-1:0]     vpe_id;
    logic [EVT_SEL_W-1:0] evt_sel;
    logic                 irq_en;
    logic                 en_user;
    logic                 en_super;
    logic                 en_kernel;
    logic                 en_exc;
  } ctl_t;

  // Writable fields of the bus word; bits 15, 30 and 31 are not stored.
  function automatic ctl_t unpack_ctl(input logic [31:0] w);
    ctl_t c;
    c.en_exc    = w[0];
    c.en_kernel = w[1];
    c.en_super  = w[2];
    c.en_user   = w[3];
    c.irq_en    = w[4];
    c.evt_sel   = w[14:5];
    c.vpe_id    = w[19:16];
    c.filt      = thr_filt_e'(w[21:20]);
    c.tc_id     = w[29:22];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctl(input ctl_t c, input logic more);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.en_exc;
    w[1]     = c.en_kernel;
    w[2]     = c.en_super;
    w[3]     = c.en_user;
    w[4]     = c.irq_en;
    w[14:5]  = c.evt_sel;
    w[19:16] = c.vpe_id;
    w[21:20] = c.filt;
    w[29:22] = c.tc_id;
    w[30]    = 1'b0;
    w[31]    = more;
    return w;
  endfunction

  function automatic logic mode_ok(input ctl_t c, input priv_mode_e m);
    logic ok;
    case (m)
      MODE_USER:   ok = c.en_user;
      MODE_SUPER:  ok = c.en_super;
      MODE_KERNEL: ok = c.en_kernel;
      default:     ok = c.en_exc;
    endcase
    return ok;
  endfunction

  function automatic logic thread_ok(input ctl_t c, input logic [VPE_W-1:0] v,
                                     input logic [TC_W-1:0] t);
    logic ok;
    case (c.filt)
      FLT_ANY: ok = 1'b1;
      FLT_VPE: ok = (v == c.vpe_id);
      FLT_TC:  ok = (t == c.tc_id);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [31:0] bump(input logic [31:0] x);
    return x + 32'd1;
  endfunction
endpackage

// File: rtl/pcu_slice.sv
module pcu_slice
  import pcu_pkg::*;
#(
  parameter int NUM_EVT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic                   ctr_we,
  input  logic [31:0]            wdata,
  input  priv_mode_e             mode,
  input  logic [VPE_W-1:0]       vpe,
  input  logic [TC_W-1:0]        tc,
  input  logic [NUM_EVT-1:0]     evt_pulse,
  output ctl_t                   ctl_q,
  output logic [31:0]            ctr_q,
  output logic                   inc_hit,
  output logic                   irq_req
);
  localparam int EIDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic evt_sel_hit;

  always_comb begin
    if ({1'b0, ctl_q.evt_sel} < (EVT_SEL_W+1)'(NUM_EVT))
      evt_sel_hit = evt_pulse[ctl_q.evt_sel[EIDX_W-1:0]];
    else
      evt_sel_hit = 1'b0;
  end

  assign inc_hit = evt_sel_hit && mode_ok(ctl_q, mode) && thread_ok(ctl_q, vpe, tc);
  assign irq_req = ctr_q[31] && ctl_q.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= unpack_ctl(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (ctr_we) begin
      ctr_q <= wdata;
    end else if (inc_hit) begin
      ctr_q <= bump(ctr_q);
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_we |=> ctr_q == $past(wdata)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr_we && inc_hit) |=> ctr_q == $past(ctr_q) + 32'd1); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr_we && !inc_hit) |=> $stable(ctr_q)); // R2
endmodule

// File: rtl/pcu_regmux.sv
module pcu_regmux
  import pcu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_CTR-1:0][31:0]     ctl_words,
  input  logic [NUM_CTR-1:0][31:0]     ctr_words,
  input  logic                         irq,
  output logic [31:0]                  rdata
);
  localparam int STAT_ADDR = 2 * NUM_CTR;
  localparam int CFG_ADDR  = 2 * NUM_CTR + 1;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == ADDR_W'(i))           rdata = ctl_words[i];
      if (addr == ADDR_W'(NUM_CTR + i)) rdata = ctr_words[i];
    end
    if (addr == ADDR_W'(STAT_ADDR)) rdata[PEND_BIT] = irq;
    if (addr == ADDR_W'(CFG_ADDR))  rdata[PRES_BIT] = 1'b1;
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [1:0]         cur_mode,
  input  logic [3:0]         cur_vpe,
  input  logic [7:0]         cur_tc,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq_out
);
  localparam int STAT_ADDR = 2 * NUM_CTR;

  logic [NUM_CTR-1:0][31:0] ctl_words;
  logic [NUM_CTR-1:0][31:0] ctr_words;
  logic [NUM_CTR-1:0]       hit_vec;
  logic [NUM_CTR-1:0]       req_vec;
  priv_mode_e               mode;

  assign mode = priv_mode_e'(cur_mode);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    ctl_t ctl_q;
    logic ctl_we, ctr_we;
    assign ctl_we = reg_we && (reg_addr == ADDR_W'(i));
    assign ctr_we = reg_we && (reg_addr == ADDR_W'(NUM_CTR + i));

    pcu_slice #(.NUM_EVT(NUM_EVT)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctr_we    (ctr_we),
      .wdata     (reg_wdata),
      .mode      (mode),
      .vpe       (cur_vpe),
      .tc        (cur_tc),
      .evt_pulse (evt_pulse),
      .ctl_q     (ctl_q),
      .ctr_q     (ctr_words[i]),
      .inc_hit   (hit_vec[i]),
      .irq_req   (req_vec[i])
    );

    assign ctl_words[i] = pack_ctl(ctl_q, (i < NUM_CTR - 1) ? 1'b1 : 1'b0);
  end

  assign irq_out = |req_vec;

  pcu_regmux #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_mux (
    .addr      (reg_addr),
    .ctl_words (ctl_words),
    .ctr_words (ctr_words),
    .irq       (irq_out),
    .rdata     (reg_rdata)
  );

  AST_WIDE_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(NUM_CTR)) |-> !reg_rdata[30]); // R5
  AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(reg_we) || $past(|hit_vec))); // R8
  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_ADDR)) |-> (reg_rdata[PEND_BIT] == irq_out)); // R9
endmodule

// File: tb/sim_perf_counter_unit.sv
module sim_perf_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  cur_mode = 2'd0;
  logic [3:0]  cur_vpe = '0;
  logic [7:0]  cur_tc = '0;
  logic [15:0] evt_pulse = '0;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #10 clk = ~clk;

  perf_counter_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_mode(cur_mode),
    .cur_vpe(cur_vpe), .cur_tc(cur_tc), .evt_pulse(evt_pulse), .irq_out(irq_out)
  );

  function automatic logic [31:0] mk_ctl(input logic [3:0] en, input logic ie,
      input int evt, input int vpe, input int filt, input int tc);
    return 32'(en) | (32'(ie) << 4) | (32'(evt) << 5) | (32'(vpe) << 16)
         | (32'(filt) << 20) | (32'(tc) << 22);
  endfunction

  // Monitor: pops one expectation per falling edge, shortly after it.
  initial forever begin
    @(negedge clk);
    #2;
    if (sb_q.size() != 0) begin
      exp_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? 32'(irq_out) : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_reg(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = 4'(a);
    sb_q.push_back('{1'b0, e, tag});
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    sb_q.push_back('{1'b1, 32'(e), tag});
  endtask

  task automatic pulse(input int n, input logic [15:0] m);
    @(negedge clk);
    evt_pulse = m;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_reg(0, 32'h8000_0000, "R1 ctl0 after reset");
    chk_reg(3, 32'h0000_0000, "R1 ctl3 after reset");
    chk_reg(4, 32'h0, "R1 ctr0 after reset");
    chk_reg(7, 32'h0, "R1 ctr3 after reset");
    chk_irq(1'b0, "R1 irq after reset");
    chk_reg(8, 32'h0, "R1 status after reset");
    chk_reg(9, 32'h0000_0010, "R9 config present bit");
    chk_reg(1, 32'h8000_0000, "R5 ctl1 chaining flag");
    // R5 bit 30 ignored
    wr(0, 32'h4000_0000 | mk_ctl(4'b1000, 0, 2, 0, 0, 0));
    chk_reg(0, 32'h8000_0000 | mk_ctl(4'b1000, 0, 2, 0, 0, 0), "R5 bit30 reads 0");
    // R2/R3 mode and event selection
    cur_mode = 2'd0;
    pulse(5, 16'h0004);
    chk_reg(4, 32'd5, "R2 user mode counts");
    cur_mode = 2'd2;
    pulse(5, 16'h0004);
    chk_reg(4, 32'd5, "R2 kernel mode disabled");
    cur_mode = 2'd0;
    pulse(4, 16'h0002);
    chk_reg(4, 32'd5, "R3 other event ignored");
    cur_mode = 2'd2;
    wr(1, mk_ctl(4'hF, 0, 20, 0, 0, 0));
    pulse(3, 16'hFFFF);
    chk_reg(5, 32'd0, "R3 event number out of range");
    wr(1, mk_ctl(4'b0001, 0, 0, 0, 0, 0));
    cur_mode = 2'd3;
    pulse(4, 16'h0001);
    chk_reg(5, 32'd4, "R2 exception level counts");
    // R4 thread filter
    wr(2, mk_ctl(4'hF, 0, 3, 5, 1, 0));
    chk_reg(2, 32'h8000_0000 | mk_ctl(4'hF, 0, 3, 5, 1, 0), "R4 ctl2 readback");
    cur_vpe = 4'd5;
    pulse(3, 16'h0008);
    chk_reg(6, 32'd3, "R4 vpe match counts");
    cur_vpe = 4'd4;
    pulse(3, 16'h0008);
    chk_reg(6, 32'd3, "R4 vpe mismatch blocked");
    wr(2, mk_ctl(4'hF, 0, 3, 5, 2, 8'h21));
    cur_tc = 8'h21;
    pulse(2, 16'h0008);
    chk_reg(6, 32'd5, "R4 tc match counts");
    cur_tc = 8'h20;
    pulse(2, 16'h0008);
    chk_reg(6, 32'd5, "R4 tc mismatch blocked");
    cur_tc = 8'h21; cur_vpe = 4'd5;
    wr(2, mk_ctl(4'hF, 0, 3, 5, 3, 8'h21));
    pulse(2, 16'h0008);
    chk_reg(6, 32'd5, "R4 filter 3 never counts");
    // R6 wrap
    wr(7, 32'hFFFF_FFFE);
    wr(3, mk_ctl(4'hF, 0, 4, 0, 0, 0));
    chk_reg(3, mk_ctl(4'hF, 0, 4, 0, 0, 0), "R5 last ctl chaining flag 0");
    pulse(3, 16'h0010);
    chk_reg(7, 32'd1, "R6 wrap to zero");
    // R8 interrupt
    cur_mode = 2'd0;
    wr(0, mk_ctl(4'hF, 1, 2, 0, 0, 0));
    wr(4, 32'h7FFF_FFFC);
    chk_irq(1'b0, "R8 irq low after preload");
    pulse(3, 16'h0004);
    chk_irq(1'b0, "R8 irq low before period");
    chk_reg(4, 32'h7FFF_FFFF, "R6 counter before overflow");
    pulse(1, 16'h0004);
    chk_irq(1'b1, "R8 irq after period");
    chk_reg(8, 32'h0400_0000, "R9 status pending bit");
    chk_reg(4, 32'h8000_0000, "R8 counter at overflow");
    wr(4, 32'h7FFF_FFFC);
    chk_irq(1'b0, "R8 irq cleared by write");
    wr(7, 32'h8000_0000);
    chk_irq(1'b0, "R8 no irq without enable");
    chk_reg(7, 32'h8000_0000, "R8 ctr3 bit31 set");
    // R7 write beats increment
    @(negedge clk);
    evt_pulse = 16'h0004; reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0000_0100;
    @(negedge clk);
    reg_we = 1'b0; evt_pulse = '0;
    chk_reg(4, 32'h0000_0100, "R7 write wins over event");
    // R9 status/config read-only
    wr(9, 32'hFFFF_FFFF);
    chk_reg(9, 32'h0000_0010, "R9 config write ignored");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d items", sb_q.size());
    end
    finish_run();
  end
endmodule